// File: doc/BRIEF.md
# SPI Idle-Event Interrupt Logic

This block raises interrupts for an SPI controller at the moment its transmit path or its receive path stops being active. It watches three inputs: the transmit queue's empty flag, the shifter's busy flag and the chip-select line. It also sees a mode input that says whether the controller is the bus master or a slave. Each path's idle condition is worked out every cycle and compared with a registered copy of the previous cycle's condition. Only a change from active to idle records an event. A path that stays idle records nothing.

Events are kept in a status register that software clears by writing 1. An enable register with the same bit layout selects which events drive the single interrupt output. Both registers sit on a small register port with a write strobe and a combinational read. The chip-select polarity, the register addresses and the data width are parameters.

Top module: `spi_idle_irq`

## Requirements
- R1: After reset the status register and the enable register both read 0, and `irq_out` is low.
- R2: In master mode (`mode_master`=1) the transmit path is idle when `txq_empty`=1 and `shift_active`=0. When the path goes from active to idle, status bit 1 reads 1 after the next rising clock edge.
- R3: In slave mode (`mode_master`=0) the transmit path is idle when chip select is deasserted (`chip_sel`=1 with the default active-low polarity). In this mode `txq_empty` and `shift_active` have no effect on status bit 1.
- R4: In either mode, chip select going from asserted to deasserted sets status bit 0 after the next rising clock edge.
- R5: A path that stays idle raises no event. Both paths count as idle out of reset, so reset by itself sets no status bit.
- R6: Writing to the status address clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R7: The enable register is at the enable address. Bit 1 enables the transmit-idle event and bit 0 enables the receive-idle event. Bits 31..2 of both registers read 0 whatever is written to them.
- R8: `irq_out` is the OR over bits of status AND enable. It is high in the same cycle as that product becomes non-zero and stays high until the product is zero.
- R9: If an event and a write-1 clear hit the same status bit in the same cycle, the bit is set after that edge.
- R10: Reads from any address other than the status and enable addresses (defaults 0 and 1) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = controller is master, 0 = slave |
| txq_empty | input | 1 | Transmit queue is empty |
| shift_active | input | 1 | Shifter is moving data out |
| chip_sel | input | 1 | Chip-select line, already synchronized; active low by default |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request, active high |

## Verification
A change on the path inputs, or a write strobe presented before a rising edge, shows up in the status register after exactly that one edge. Register reads and `irq_out` follow the registers combinationally within the same cycle. The bench therefore drives each stimulus just after a falling edge and lets a single rising edge pass. Its scoreboard monitor then compares the read data and the interrupt a moment after the next falling edge, with no rising edge in between. Cases where nothing should change are checked in the same way after the stimulus has been held for several edges.

// File: rtl/spi_idle_irq_pkg.sv
package spi_idle_irq_pkg;

   localparam int EVT_RX  = 0;
   localparam int EVT_TX  = 1;
   localparam int EVT_NUM = 2;

   typedef logic [EVT_NUM-1:0] evt_vec_t;

endpackage

// File: rtl/spi_idle_irq_tx_sel.sv
module spi_idle_irq_tx_sel (
   input  logic mode_master,
   input  logic txq_empty,
   input  logic shift_active,
   input  logic cs_idle,
   output logic tx_idle
);
   // master: queue drained and shifter stopped; slave: chip select released
   always_comb begin
      if (mode_master) tx_idle = txq_empty & ~shift_active;
      else             tx_idle = cs_idle;
   end
endmodule

// File: rtl/spi_idle_irq_edge.sv
module spi_idle_irq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_now,
   output logic fire
);
   logic idle_q;

   // reset to idle so leaving reset is not a transition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_q <= 1'b1;
      else        idle_q <= idle_now;
   end

   assign fire = idle_now & ~idle_q;
endmodule

// File: rtl/spi_idle_irq_w1c.sv
module spi_idle_irq_w1c #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[b] <= 1'b0;
            else if (set_i[b]) q[b] <= 1'b1;   // a new event beats a clear
            else if (clr_i[b]) q[b] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/spi_idle_irq.sv
module spi_idle_irq
   import spi_idle_irq_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 4,
   parameter int STATUS_ADDR   = 0,
   parameter int ENABLE_ADDR   = 1,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_master,
   input  logic              txq_empty,
   input  logic              shift_active,
   input  logic              chip_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(ENABLE_ADDR);

   generate
      if (DATA_W <= EVT_NUM) begin : g_bad_width
         $error("spi_idle_irq: DATA_W must exceed the event count");
      end
      if (STATUS_ADDR == ENABLE_ADDR) begin : g_bad_addr
         $error("spi_idle_irq: status and enable addresses collide");
      end
      if (STATUS_ADDR >= (1 << ADDR_W) || ENABLE_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("spi_idle_irq: register address does not fit ADDR_W");
      end
   endgenerate

   logic cs_idle;
   generate
      if (CS_ACTIVE_LOW) begin : g_cs_low
         assign cs_idle = chip_sel;
      end else begin : g_cs_high
         assign cs_idle = ~chip_sel;
      end
   endgenerate

   logic tx_idle_now;
   logic tx_event;
   logic rx_event;

   spi_idle_irq_tx_sel u_tx_sel (
      .mode_master (mode_master),
      .txq_empty   (txq_empty),
      .shift_active(shift_active),
      .cs_idle     (cs_idle),
      .tx_idle     (tx_idle_now)
   );

   spi_idle_irq_edge u_tx_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle_now(tx_idle_now),
      .fire    (tx_event)
   );

   spi_idle_irq_edge u_rx_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle_now(cs_idle),
      .fire    (rx_event)
   );

   evt_vec_t evt_set;
   evt_vec_t evt_clr;
   evt_vec_t status_q;
   evt_vec_t enable_q;
   logic     sts_wr;
   logic     en_wr;

   assign sts_wr = bus_wr && (bus_addr == STS_A);
   assign en_wr  = bus_wr && (bus_addr == EN_A);

   always_comb begin
      evt_set         = '0;
      evt_set[EVT_TX] = tx_event;
      evt_set[EVT_RX] = rx_event;
      evt_clr         = sts_wr ? bus_wdata[EVT_NUM-1:0] : '0;
   end

   spi_idle_irq_w1c #(.WIDTH(EVT_NUM)) u_status (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(evt_set),
      .clr_i(evt_clr),
      .q    (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     enable_q <= '0;
      else if (en_wr) enable_q <= bus_wdata[EVT_NUM-1:0];
   end

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:EVT_NUM];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == STS_A)     bus_rdata[EVT_NUM-1:0] = status_q;
      else if (bus_addr == EN_A) bus_rdata[EVT_NUM-1:0] = enable_q;
   end

   assign irq_out = |(status_q & enable_q);

endmodule

// File: rtl/spi_idle_irq_chk.sv
module spi_idle_irq_chk
   import spi_idle_irq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int STATUS_ADDR = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [EVT_NUM-1:0] wdata_lo,
   input logic               tx_ev,
   input logic               rx_ev,
   input logic [EVT_NUM-1:0] sts,
   input logic               irq
);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STATUS_ADDR);

   logic clr_rx;
   logic clr_tx;
   assign clr_rx = bus_wr && (bus_addr == STS_A) && wdata_lo[EVT_RX];
   assign clr_tx = bus_wr && (bus_addr == STS_A) && wdata_lo[EVT_TX];

   // R2 / R3: a transmit-idle transition is recorded on the next edge
   p_tx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ev |=> sts[EVT_TX]);

   // R4 and R9: a receive-idle transition is recorded even against a clear
   p_rx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ev |=> sts[EVT_RX]);

   // R6: write 1 clears when no event competes
   p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rx && !rx_ev) |=> !sts[EVT_RX]);

   // R6: a set bit holds unless cleared
   p_w1c_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[EVT_TX] && !clr_tx) |=> sts[EVT_TX]);

   // R5: no status bit appears without a transition
   p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts[EVT_RX] && !rx_ev) |=> !sts[EVT_RX]);

   // R8: the interrupt rises only after an event or a register write
   p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(tx_ev) || $past(rx_ev) || $past(bus_wr)));

endmodule

bind spi_idle_irq spi_idle_irq_chk #(
   .ADDR_W     (ADDR_W),
   .STATUS_ADDR(STATUS_ADDR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .wdata_lo(bus_wdata[1:0]),
   .tx_ev   (tx_event),
   .rx_ev   (rx_event),
   .sts     (status_q),
   .irq     (irq_out)
);

// File: tb/spi_idle_irq_bench.sv
`timescale 1ns/1ps
module spi_idle_irq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_master = 1'b1;
   logic        txq_empty = 1'b1;
   logic        shift_active = 1'b0;
   logic        chip_sel = 1'b1;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   localparam logic [3:0] A_STS = 4'd0;
   localparam logic [3:0] A_EN  = 4'd1;

   always #5 clk = ~clk;

   spi_idle_irq u_spi_idle_irq (
      .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
      .txq_empty(txq_empty), .shift_active(shift_active), .chip_sel(chip_sel),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   typedef struct {
      logic [31:0] data;
      logic        irq;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   pushed = 0;
   int   popped = 0;
   bit   done = 0;

   // monitor: compares each expected item a moment after it is posted
   initial begin
      forever begin
         wait (exp_q.size() != 0);
         #1;
         begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (bus_rdata !== it.data || irq_out !== it.irq) begin
               errors++;
               $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                        it.tag, bus_rdata, irq_out, it.data, it.irq);
            end
         end
         popped++;
      end
   end

   task automatic expect_reg(input logic [3:0] a, input logic [31:0] d,
                             input logic irq, input string tag);
      exp_t it;
      bus_addr = a;
      it.data = d; it.irq = irq; it.tag = tag;
      exp_q.push_back(it);
      pushed++;
      wait (popped == pushed);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run incomplete expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      expect_reg(A_STS, 32'h0, 1'b0, "R1 status");
      expect_reg(A_EN,  32'h0, 1'b0, "R1 enable");
      // R5 staying idle raises nothing
      step(4);
      expect_reg(A_STS, 32'h0, 1'b0, "R5 idle hold");

      // R7 enable only keeps two bits
      reg_write(A_EN, 32'hFFFF_FFFF);
      expect_reg(A_EN, 32'h3, 1'b0, "R7 enable readback");
      reg_write(A_STS, 32'hFFFF_FFFC);
      expect_reg(A_STS, 32'h0, 1'b0, "R7 upper status bits");
      expect_reg(4'd7, 32'h0, 1'b0, "R10 unmapped read");

      // R2 master: shifter busy then stops
      shift_active = 1'b1; step(1);
      expect_reg(A_STS, 32'h0, 1'b0, "R2 while active");
      shift_active = 1'b0; step(1);
      expect_reg(A_STS, 32'h2, 1'b1, "R2 shifter stop");

      // R6 write 0 keeps, write 1 clears
      reg_write(A_STS, 32'h1);
      expect_reg(A_STS, 32'h2, 1'b1, "R6 zero keeps");
      reg_write(A_STS, 32'h2);
      expect_reg(A_STS, 32'h0, 1'b0, "R6 one clears");

      // R2 master: queue refills then drains
      txq_empty = 1'b0; step(2);
      txq_empty = 1'b1; step(1);
      expect_reg(A_STS, 32'h2, 1'b1, "R2 queue drain");
      reg_write(A_STS, 32'h2);

      // R4 receive idle in master mode
      chip_sel = 1'b0; step(2);
      expect_reg(A_STS, 32'h0, 1'b0, "R4 cs asserted");
      chip_sel = 1'b1; step(1);
      expect_reg(A_STS, 32'h1, 1'b1, "R4 cs released master");
      reg_write(A_STS, 32'h1);

      // R3 slave: queue and shifter ignored
      mode_master = 1'b0; step(2);
      expect_reg(A_STS, 32'h0, 1'b0, "R3 mode switch");
      shift_active = 1'b1; txq_empty = 1'b0; step(2);
      shift_active = 1'b0; txq_empty = 1'b1; step(2);
      expect_reg(A_STS, 32'h0, 1'b0, "R3 shifter ignored");
      chip_sel = 1'b0; step(2);
      chip_sel = 1'b1; step(1);
      expect_reg(A_STS, 32'h3, 1'b1, "R3 slave cs release");

      // R8 interrupt masking
      reg_write(A_EN, 32'h1);
      expect_reg(A_STS, 32'h3, 1'b1, "R8 rx enabled");
      reg_write(A_STS, 32'h1);
      expect_reg(A_STS, 32'h2, 1'b0, "R8 tx masked");
      reg_write(A_EN, 32'h2);
      expect_reg(A_STS, 32'h2, 1'b1, "R8 tx enabled");
      reg_write(A_EN, 32'h0);
      expect_reg(A_STS, 32'h2, 1'b0, "R8 all masked");

      // R9 event against clear in the same cycle
      chip_sel = 1'b0; step(1);
      chip_sel = 1'b1;
      reg_write(A_STS, 32'h3);
      expect_reg(A_STS, 32'h3, 1'b0, "R9 event wins");
      reg_write(A_STS, 32'h3);
      expect_reg(A_STS, 32'h0, 1'b0, "R6 clear both");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule